// File: doc/BRIEF.md
# Bitwise Logic Unit with Status Flags

This block evaluates one Boolean or negation operation per accepted strobe. The operations are AND, OR, XOR, AND-NOT, one's-complement inversion and two's-complement negation. Each works on a destination operand and a source operand, and the source can be replaced by a short immediate. In scalar mode the operation is confined to 8, 16, 32 or 64 bits, and a six-bit status word is kept up to date. The status word follows per-operation rules: some operations clear flags, inversion leaves every flag untouched, and negation derives carry from the operand. In packed mode the same bitwise operations act on the full 128-bit vector, or on its low 64 bits in the narrow packed form. No bit affects any other bit, and the status word is never written in packed mode.

The result and the status word are registered. A small two-state controller produces the result-valid output. State `ST_IDLE` means no fresh result is present. State `ST_RESULT` means the registers were loaded on the previous edge. An accepted strobe always takes the controller to `ST_RESULT` (transitions IDLE→RESULT and RESULT→RESULT). A cycle without an accepted strobe always returns it to `ST_IDLE` (transitions RESULT→IDLE and IDLE→IDLE). Reset forces `ST_IDLE`.

Top module: `bitlogic_unit`

## Requirements
- R1: Opcode encoding is 0 AND, 1 OR, 2 XOR, 3 AND-NOT, 4 NOT, 5 NEG. AND-NOT yields (~dst) & src. The width select is 0→8, 1→16, 2→32 and 3→64 bits. Every result bit above the selected width reads 0.
- R2: In scalar mode, AND, OR, XOR and AND-NOT do the following to the status word, whose bit order is {OF,SF,ZF,AF,PF,CF} = bits [5:0]. They force OF and CF to 0. They set ZF exactly when the width-limited result is 0. They copy the result's top bit at the selected width into SF. They set PF to 1 when the low byte of the result has an even number of ones. They keep AF at its previous value.
- R3: NOT returns the bitwise inverse of dst within the width and leaves all six status bits unchanged.
- R4: NEG returns (~dst)+1 within the width. CF is 1 exactly when the width-limited dst is nonzero. OF is 1 exactly when dst is the most negative value of the width. AF is 1 when dst[3:0] is nonzero. SF, ZF and PF follow the result, by the same rules as in R2.
- R5: With the immediate select high in scalar mode, the immediate replaces src. With the wide-immediate input low, imm[7:0] is sign-extended. With it high, the 32-bit immediate is sign-extended, so it fills 64-bit operands and is truncated for narrower ones.
- R6: Packed mode acts on 128 bits, or on the low 64 bits when the width select is 3 (upper 64 result bits 0). It ignores the immediate select and never changes the status word.
- R7: Some strobes are rejected: NEG in packed mode, and opcodes 6 and 7. A rejected strobe produces no result-valid pulse and leaves the result and the status word unchanged.
- R8: result-valid is high in the cycle after each accepted strobe, so back-to-back strobes keep it high. Without a strobe, result-valid is low and the result and status word hold.
- R9: Reset clears the result, the status word and result-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vld_i | input | 1 | Operation strobe |
| op_i | input | 3 | Opcode |
| wsel_i | input | 2 | Width select |
| pk_i | input | 1 | 1 = packed mode |
| imm_sel_i | input | 1 | 1 = immediate replaces source (scalar) |
| imm_wide_i | input | 1 | 1 = 32-bit immediate, 0 = 8-bit |
| imm_i | input | 32 | Immediate value |
| dst_i | input | 128 | Destination operand |
| src_i | input | 128 | Source operand |
| res_o | output | 128 | Registered result |
| flags_o | output | 6 | Status word {OF,SF,ZF,AF,PF,CF} |
| res_vld_o | output | 1 | Result valid |

## Verification
The bench builds the unit with its defaults: a 128-bit vector, a 32-bit immediate and a 64-bit scalar limit. With these values, every scalar width reaches a top bit for SF and a most-negative NEG case. The 32-bit immediate can also be shown to sign-extend into the upper half of a 64-bit operand. The default vector width is twice the scalar limit, so the narrow packed form covers exactly the low half. This makes the masking of the upper 64 bits visible at the result port.

// File: rtl/bitlogic_pkg.sv
package bitlogic_pkg;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_XOR  = 3'd2,
        OP_ANDN = 3'd3,
        OP_NOT  = 3'd4,
        OP_NEG  = 3'd5
    } op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } state_e;

    localparam int FL_W  = 6;
    localparam int FL_CF = 0;
    localparam int FL_PF = 1;
    localparam int FL_AF = 2;
    localparam int FL_ZF = 3;
    localparam int FL_SF = 4;
    localparam int FL_OF = 5;

    localparam int N_WIDTHS = 4;

    function automatic logic is_logic_op(input logic [2:0] op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR) || (op == OP_ANDN);
    endfunction

endpackage

// File: rtl/bl_operand_prep.sv
module bl_operand_prep
    import bitlogic_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int IMM_W  = 32,
    parameter int SCAL_W = 64
) (
    input  logic             pk_i,
    input  logic             imm_sel_i,
    input  logic             imm_wide_i,
    input  logic [1:0]       wsel_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [VEC_W-1:0] dst_i,
    input  logic [VEC_W-1:0] src_i,
    output logic [VEC_W-1:0] mask_o,
    output logic [VEC_W-1:0] a_o,
    output logic [VEC_W-1:0] b_o
);

    localparam int PK_NARROW = VEC_W / 2;

    logic [VEC_W-1:0] wmask [N_WIDTHS];
    logic [VEC_W-1:0] sx_short;
    logic [VEC_W-1:0] sx_long;
    logic [VEC_W-1:0] mask;
    logic [VEC_W-1:0] b_sel;

    // One mask per scalar width: 8 << g bits set
    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_wmask
        assign wmask[g] = {{(VEC_W - (8 << g)){1'b0}}, {(8 << g){1'b1}}};
    end

    assign sx_short = {{(VEC_W - 8){imm_i[7]}}, imm_i[7:0]};
    assign sx_long  = {{(VEC_W - IMM_W){imm_i[IMM_W-1]}}, imm_i};

    always_comb begin
        if (pk_i) begin
            mask  = (wsel_i == 2'd3) ? {{(VEC_W - PK_NARROW){1'b0}}, {PK_NARROW{1'b1}}}
                                     : {VEC_W{1'b1}};
            b_sel = src_i;
        end else begin
            mask  = wmask[wsel_i];
            b_sel = imm_sel_i ? (imm_wide_i ? sx_long : sx_short) : src_i;
        end
    end

    assign mask_o = mask;
    assign a_o    = dst_i & mask;
    assign b_o    = b_sel & mask;

endmodule

// File: rtl/bl_logic_core.sv
module bl_logic_core
    import bitlogic_pkg::*;
#(
    parameter int VEC_W = 128
) (
    input  logic [2:0]       op_i,
    input  logic [VEC_W-1:0] a_i,
    input  logic [VEC_W-1:0] b_i,
    input  logic [VEC_W-1:0] mask_i,
    output logic [VEC_W-1:0] res_o
);

    logic [VEC_W-1:0] raw;

    always_comb begin
        unique case (op_i)
            OP_AND:  raw = a_i & b_i;
            OP_OR:   raw = a_i | b_i;
            OP_XOR:  raw = a_i ^ b_i;
            OP_ANDN: raw = ~a_i & b_i;
            OP_NOT:  raw = ~a_i;
            OP_NEG:  raw = ~a_i + VEC_W'(1);
            default: raw = '0;
        endcase
    end

    assign res_o = raw & mask_i;

endmodule

// File: rtl/bl_flag_gen.sv
module bl_flag_gen
    import bitlogic_pkg::*;
#(
    parameter int SCAL_W = 64
) (
    input  logic [2:0]        op_i,
    input  logic [1:0]        wsel_i,
    input  logic [SCAL_W-1:0] a_i,
    input  logic [SCAL_W-1:0] res_i,
    input  logic [FL_W-1:0]   flags_q_i,
    output logic [FL_W-1:0]   flags_d_o
);

    logic [N_WIDTHS-1:0] r_top;
    logic [N_WIDTHS-1:0] a_top;
    logic sf, zf, pf;

    for (genvar g = 0; g < N_WIDTHS; g++) begin : g_top
        assign r_top[g] = res_i[(8 << g) - 1];
        assign a_top[g] = a_i[(8 << g) - 1];
    end

    assign sf = r_top[wsel_i];
    assign zf = (res_i == '0);
    assign pf = ~^res_i[7:0];

    always_comb begin
        flags_d_o = flags_q_i;
        if (is_logic_op(op_i)) begin
            flags_d_o[FL_OF] = 1'b0;
            flags_d_o[FL_CF] = 1'b0;
            flags_d_o[FL_SF] = sf;
            flags_d_o[FL_ZF] = zf;
            flags_d_o[FL_PF] = pf;
        end else if (op_i == OP_NEG) begin
            flags_d_o[FL_CF] = (a_i != '0);
            flags_d_o[FL_OF] = a_top[wsel_i] & sf;
            flags_d_o[FL_AF] = (a_i[3:0] != 4'd0);
            flags_d_o[FL_SF] = sf;
            flags_d_o[FL_ZF] = zf;
            flags_d_o[FL_PF] = pf;
        end
    end

endmodule

// File: rtl/bitlogic_unit.sv
module bitlogic_unit
    import bitlogic_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int IMM_W  = 32,
    parameter int SCAL_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vld_i,
    input  logic [2:0]       op_i,
    input  logic [1:0]       wsel_i,
    input  logic             pk_i,
    input  logic             imm_sel_i,
    input  logic             imm_wide_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [VEC_W-1:0] dst_i,
    input  logic [VEC_W-1:0] src_i,
    output logic [VEC_W-1:0] res_o,
    output logic [FL_W-1:0]  flags_o,
    output logic             res_vld_o
);

    logic [VEC_W-1:0] mask, a_m, b_m, res_d, res_q;
    logic [FL_W-1:0]  flags_d, flags_q;
    logic             op_legal, accept;
    state_e           state_q, state_d;

    bl_operand_prep #(.VEC_W(VEC_W), .IMM_W(IMM_W), .SCAL_W(SCAL_W)) u_prep (
        .pk_i       (pk_i),
        .imm_sel_i  (imm_sel_i),
        .imm_wide_i (imm_wide_i),
        .wsel_i     (wsel_i),
        .imm_i      (imm_i),
        .dst_i      (dst_i),
        .src_i      (src_i),
        .mask_o     (mask),
        .a_o        (a_m),
        .b_o        (b_m)
    );

    bl_logic_core #(.VEC_W(VEC_W)) u_core (
        .op_i   (op_i),
        .a_i    (a_m),
        .b_i    (b_m),
        .mask_i (mask),
        .res_o  (res_d)
    );

    bl_flag_gen #(.SCAL_W(SCAL_W)) u_flags (
        .op_i      (op_i),
        .wsel_i    (wsel_i),
        .a_i       (a_m[SCAL_W-1:0]),
        .res_i     (res_d[SCAL_W-1:0]),
        .flags_q_i (flags_q),
        .flags_d_o (flags_d)
    );

    assign op_legal = (op_i <= OP_NEG) && !(pk_i && (op_i == OP_NEG));
    assign accept   = vld_i && op_legal;

    // Controller: next state
    always_comb begin
        unique case (state_q)
            ST_IDLE:   state_d = accept ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_d = accept ? ST_RESULT : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Controller: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Controller: outputs
    always_comb begin
        res_vld_o = (state_q == ST_RESULT);
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (accept) begin
            res_q <= res_d;
            if (!pk_i) flags_q <= flags_d;
        end
    end

    assign res_o   = res_q;
    assign flags_o = flags_q;

    // R8: valid follows acceptance by exactly one cycle
    a_r8_vld_tracks_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> res_vld_o);
    a_r8_no_vld_without_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !res_vld_o);

    // R7: rejected strobes leave result and status untouched
    a_r7_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_i && !op_legal) |=> ($stable(res_o) && $stable(flags_o)));

    // R2: logic ops clear carry and overflow
    a_r2_logic_clears_cf_of: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pk_i && is_logic_op(op_i)) |=> (!flags_o[FL_CF] && !flags_o[FL_OF]));

    // R3: NOT keeps every flag
    a_r3_not_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && op_i == OP_NOT) |=> $stable(flags_o));

    // R6: packed mode never writes flags
    a_r6_packed_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && pk_i) |=> $stable(flags_o));

    // R4: NEG carry reflects a nonzero operand
    a_r4_neg_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !pk_i && op_i == OP_NEG) |=> (flags_o[FL_CF] == ($past(a_m) != '0)));

endmodule

// File: tb/bitlogic_unit_tb.sv
`timescale 1ns/1ps
module bitlogic_unit_tb;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  w;
        logic        isel;
        logic        iwide;
        logic [63:0] dst;
        logic [63:0] src;
        logic [31:0] imm;
        logic [63:0] res;
        logic [5:0]  fl;
    } vec_t;

    localparam int NV = 15;
    // flags order {OF,SF,ZF,AF,PF,CF}
    localparam vec_t TBL [NV] = '{
        '{3'd0, 2'd0, 1'b0, 1'b0, 64'h1111_0000_0000_00F0, 64'h3C, 32'h0, 64'h30, 6'b000010},
        '{3'd1, 2'd1, 1'b0, 1'b0, 64'hFFFF_0000_0000_8001, 64'h0100, 32'h0, 64'h8101, 6'b010000},
        '{3'd2, 2'd2, 1'b0, 1'b0, 64'h1234_5678, 64'h1234_5678, 32'h0, 64'h0, 6'b001010},
        '{3'd3, 2'd3, 1'b0, 1'b0, 64'h00FF_00FF_00FF_00FF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, 64'hFF00_FF00_FF00_FF00, 6'b010010},
        '{3'd5, 2'd0, 1'b0, 1'b0, 64'h01, 64'h0, 32'h0, 64'hFF, 6'b010111},
        '{3'd0, 2'd0, 1'b1, 1'b0, 64'hAB, 64'hFF, 32'h0F, 64'h0B, 6'b000100},
        '{3'd4, 2'd1, 1'b0, 1'b0, 64'h00F0, 64'h1234, 32'h0, 64'hFF0F, 6'b000100},
        '{3'd5, 2'd0, 1'b0, 1'b0, 64'h80, 64'h0, 32'h0, 64'h80, 6'b110001},
        '{3'd5, 2'd2, 1'b0, 1'b0, 64'h0, 64'h0, 32'h0, 64'h0, 6'b001010},
        '{3'd1, 2'd3, 1'b1, 1'b0, 64'h0, 64'h0, 32'h80, 64'hFFFF_FFFF_FFFF_FF80, 6'b010000},
        '{3'd2, 2'd3, 1'b1, 1'b1, 64'h0, 64'h0, 32'h8000_0001, 64'hFFFF_FFFF_8000_0001, 6'b010000},
        '{3'd1, 2'd1, 1'b1, 1'b0, 64'h0001, 64'h0, 32'hFE, 64'hFFFF, 6'b010010},
        '{3'd0, 2'd2, 1'b1, 1'b1, 64'hABCD_1234, 64'h0, 32'h0000_FFFF, 64'h1234, 6'b000000},
        '{3'd5, 2'd1, 1'b0, 1'b0, 64'h0005, 64'h0, 32'h0, 64'hFFFB, 6'b010101},
        '{3'd3, 2'd0, 1'b0, 1'b0, 64'h0F, 64'hFF, 32'h0, 64'hF0, 6'b010110}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         vld_i = 1'b0;
    logic [2:0]   op_i = '0;
    logic [1:0]   wsel_i = '0;
    logic         pk_i = 1'b0;
    logic         imm_sel_i = 1'b0;
    logic         imm_wide_i = 1'b0;
    logic [31:0]  imm_i = '0;
    logic [127:0] dst_i = '0;
    logic [127:0] src_i = '0;
    logic [127:0] res_o;
    logic [5:0]   flags_o;
    logic         res_vld_o;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bitlogic_unit u_dut (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i), .wsel_i(wsel_i),
        .pk_i(pk_i), .imm_sel_i(imm_sel_i), .imm_wide_i(imm_wide_i), .imm_i(imm_i),
        .dst_i(dst_i), .src_i(src_i), .res_o(res_o), .flags_o(flags_o),
        .res_vld_o(res_vld_o)
    );

    task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Drive at a falling edge, strobe across one rising edge, return at the next falling edge
    task automatic issue(input logic [2:0] op, input logic [1:0] w, input logic pk,
                         input logic isel, input logic iwide, input logic [31:0] imm,
                         input logic [127:0] dst, input logic [127:0] src);
        op_i = op; wsel_i = w; pk_i = pk; imm_sel_i = isel; imm_wide_i = iwide;
        imm_i = imm; dst_i = dst; src_i = src; vld_i = 1'b1;
        @(negedge clk);
        vld_i = 1'b0;
    endtask

    function automatic string res_tag(input vec_t v);
        if (v.isel) return "R5 result";
        if (v.op == 3'd4) return "R3 result";
        if (v.op == 3'd5) return "R4 result";
        return "R1 result";
    endfunction

    function automatic string fl_tag(input vec_t v);
        if (v.isel) return "R5 flags";
        if (v.op == 3'd4) return "R3 flags";
        if (v.op == 3'd5) return "R4 flags";
        return "R2 flags";
    endfunction

    initial begin
        logic [127:0] held;
        @(negedge clk);
        @(negedge clk);
        check("R9 reset result", res_o, '0);
        check("R9 reset flags", {122'd0, flags_o}, '0);
        check("R9 reset valid", {127'd0, res_vld_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            issue(TBL[i].op, TBL[i].w, 1'b0, TBL[i].isel, TBL[i].iwide, TBL[i].imm,
                  {64'hDEAD_BEEF_0000_0001, TBL[i].dst}, {64'h5555_0000_AAAA_FFFF, TBL[i].src});
            check("R8 valid", {127'd0, res_vld_o}, 128'd1);
            check(res_tag(TBL[i]), res_o, {64'd0, TBL[i].res});
            check(fl_tag(TBL[i]), {122'd0, flags_o}, {122'd0, TBL[i].fl});
        end

        // R6: packed full width, immediate ignored, flags kept (010110)
        issue(3'd0, 2'd0, 1'b1, 1'b1, 1'b1, 32'hFFFF_FFFF,
              128'hFFFF0000_AAAA5555_0F0F0F0F_12345678,
              128'h00FFFF00_FFFF0000_FFFFFFFF_0000FFFF);
        check("R6 packed AND", res_o, 128'h00FF0000_AAAA0000_0F0F0F0F_00005678);
        check("R6 packed flags", {122'd0, flags_o}, {122'd0, 6'b010110});

        // R6: narrow packed clears the upper half
        issue(3'd2, 2'd3, 1'b1, 1'b0, 1'b0, 32'h0, {128{1'b1}},
              128'h12345678_9ABCDEF0_00000000_FFFFFFFF);
        check("R6 narrow packed XOR", res_o, 128'h0000_0000_0000_0000_FFFF_FFFF_0000_0000);

        // R6: packed NOT
        issue(3'd4, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, '0, '0);
        check("R6 packed NOT", res_o, {128{1'b1}});
        check("R6 packed NOT flags", {122'd0, flags_o}, {122'd0, 6'b010110});

        // R7: packed NEG rejected
        issue(3'd5, 2'd0, 1'b1, 1'b0, 1'b0, 32'h0, 128'h5, '0);
        check("R7 packed NEG valid", {127'd0, res_vld_o}, '0);
        check("R7 packed NEG result", res_o, {128{1'b1}});
        check("R7 packed NEG flags", {122'd0, flags_o}, {122'd0, 6'b010110});

        // R7: reserved opcode rejected
        issue(3'd7, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, '0, '0);
        check("R7 reserved valid", {127'd0, res_vld_o}, '0);
        check("R7 reserved result", res_o, {128{1'b1}});
        check("R7 reserved flags", {122'd0, flags_o}, {122'd0, 6'b010110});

        // R8: no strobe, outputs hold
        held = res_o;
        op_i = 3'd0; pk_i = 1'b0; wsel_i = 2'd0; dst_i = '0; src_i = '0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 idle valid", {127'd0, res_vld_o}, '0);
            check("R8 idle result", res_o, held);
        end

        // R8: back-to-back strobes
        issue(3'd2, 2'd0, 1'b0, 1'b0, 1'b0, 32'h0, 128'h5A, 128'hFF);
        check("R8 b2b first valid", {127'd0, res_vld_o}, 128'd1);
        check("R8 b2b first result", res_o, 128'hA5);
        check("R2 b2b first flags", {122'd0, flags_o}, {122'd0, 6'b010110});
        issue(3'd1, 2'd1, 1'b0, 1'b0, 1'b0, 32'h0, 128'h0, 128'h0100);
        check("R8 b2b second valid", {127'd0, res_vld_o}, 128'd1);
        check("R8 b2b second result", res_o, 128'h0100);
        check("R2 b2b second flags", {122'd0, flags_o}, {122'd0, 6'b000110});
        @(negedge clk);
        check("R8 pulse ends", {127'd0, res_vld_o}, '0);

        // R9: reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 rerun result", res_o, '0);
        check("R9 rerun flags", {122'd0, flags_o}, '0);
        check("R9 rerun valid", {127'd0, res_vld_o}, '0);

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule